// File: doc/BRIEF.md
# Nibble-Wide Host Bus Interface

This block sits between a host with a 4-bit data bus and a controller whose instruction and data registers are each a full byte wide. The host sends every byte as two nibble writes: first the high half, then the low half. The block joins the two halves into one byte. It then sends that byte to the instruction register or to the data register, using the register-select level that came with the high nibble. The choice shows up as a single-cycle write strobe.

A busy flag marks the internal operation that follows each byte. Here a fixed-length counter stands in for that operation. The host can poll the flag, and it appears on the top bus line during a status read. The host only needs to consult the flag before a high nibble. A host that never polls must leave ten idle clocks after each byte. If a high nibble arrives while the flag is up, the block discards it and pulses an error output.

Top module: `nibble_bus_if`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `inst_wr`, `data_wr`, `busy` and `err` are 0, `wr_byte` is 0, and the next accepted nibble write is taken as a high nibble.
- R2: A nibble write is a clock edge with `en`=1 and `rd_nwr`=0. A high nibble H followed by a low nibble L presents `wr_byte` = {H, L} (H in bits 7..4) from the cycle after the low nibble's edge. `wr_byte` holds until the next completed byte.
- R3: The level of `reg_sel` at the high nibble picks the target: 0 selects the instruction register (`inst_wr`), 1 selects the data register (`data_wr`). Its level at the low nibble is ignored. At most one strobe is high at a time.
- R4: A strobe is high only in the single cycle that follows a low nibble's edge. A high nibble never produces a strobe.
- R5: `busy` rises in the same cycle as the strobe and stays high for exactly 10 cycles. A high nibble is therefore accepted no sooner than the 11th edge after the low nibble.
- R6: A high nibble write while `busy` is 1 is discarded. `err` is high for the following cycle only, and the next nibble is still expected to be a high nibble.
- R7: With `rd_nwr`=1 and `reg_sel`=0, `db_out` = {`busy`, 3'b000} in the same cycle. In every other case `db_out` is 0.
- R8: Read edges (`en`=1, `rd_nwr`=1) and edges with `en`=0 leave the high/low ordering and `wr_byte` unchanged. A read between the two halves does not disturb the byte being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 instruction/status, 1 data |
| rd_nwr | input | 1 | 1 read, 0 write |
| en | input | 1 | Transfer qualifier, sampled at each edge |
| db_in | input | 4 | Nibble from the host |
| db_out | output | 4 | Status nibble to the host, busy on bit 3 |
| wr_byte | output | 8 | Most recently assembled byte |
| inst_wr | output | 1 | One-cycle write strobe to the instruction register |
| data_wr | output | 1 | One-cycle write strobe to the data register |
| busy | output | 1 | Internal operation in progress |
| err | output | 1 | One-cycle pulse: high nibble rejected while busy |

## Verification
Strobes, `wr_byte` and `err` are registered, so they belong to the cycle after the edge that took the nibble. `busy` rises in that same cycle and falls after ten cycles. `db_out` is combinational, so it follows the current select and read/write levels together with the present busy flag. The bench applies each stimulus just after a rising edge, and it advances a reference model at the next edge. A quarter period later it compares every output with the model, so each result is checked in exactly the cycle it is due. Directed cases hit the tenth and eleventh edges after a byte, a read between halves, and a change of select between the two halves.

// File: rtl/nbi_pkg.sv
package nbi_pkg;

    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_e;

    typedef enum logic {
        TGT_INST = 1'b0,
        TGT_DATA = 1'b1
    } target_e;

    typedef struct packed {
        logic inst;
        logic data;
    } strobe_t;

    function automatic strobe_t route_strobe(input target_e tgt);
        strobe_t s;
        s.inst = (tgt == TGT_INST);
        s.data = (tgt == TGT_DATA);
        return s;
    endfunction

endpackage

// File: rtl/nbi_busy_timer.sv
module nbi_busy_timer #(
    parameter int BUSY_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/nbi_nibble_asm.sv
module nbi_nibble_asm
    import nbi_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_req,
    input  logic               rs,
    input  logic [NIB_W-1:0]   nib,
    input  logic               busy,
    output logic [2*NIB_W-1:0] byte_q,
    output strobe_t            stb_q,
    output logic               err_q,
    output logic               at_lower,
    output logic               complete
);
    half_e              half_q;
    target_e            tgt_q;
    logic [NIB_W-1:0]   hi_q;
    logic               take_hi;
    logic               reject_hi;

    assign take_hi   = wr_req && (half_q == HALF_UPPER) && !busy;
    assign reject_hi = wr_req && (half_q == HALF_UPPER) && busy;
    assign complete  = wr_req && (half_q == HALF_LOWER);
    assign at_lower  = (half_q == HALF_LOWER);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HALF_UPPER;
            tgt_q  <= TGT_INST;
            hi_q   <= '0;
            byte_q <= '0;
            stb_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            stb_q <= '0;
            err_q <= reject_hi;
            if (take_hi) begin
                hi_q   <= nib;
                tgt_q  <= target_e'(rs);
                half_q <= HALF_LOWER;
            end
            if (complete) begin
                byte_q <= {hi_q, nib};
                stb_q  <= route_strobe(tgt_q);
                half_q <= HALF_UPPER;
            end
        end
    end

endmodule

// File: rtl/nbi_status_rd.sv
module nbi_status_rd #(
    parameter int NIB_W = 4
) (
    input  logic             rd_status,
    input  logic             busy,
    output logic [NIB_W-1:0] db_out
);
    localparam int LOW_W = NIB_W - 1;

    always_comb begin
        db_out = '0;
        if (rd_status) begin
            db_out = {busy, {LOW_W{1'b0}}};
        end
    end

endmodule

// File: rtl/nibble_bus_if.sv
module nibble_bus_if
    import nbi_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int BUSY_CYCLES = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               rd_nwr,
    input  logic               en,
    input  logic [NIB_W-1:0]   db_in,
    output logic [NIB_W-1:0]   db_out,
    output logic [2*NIB_W-1:0] wr_byte,
    output logic               inst_wr,
    output logic               data_wr,
    output logic               busy,
    output logic               err
);
    strobe_t stb;
    logic    complete;
    logic    at_lower;
    logic    wr_req;

    assign wr_req = en && !rd_nwr;

    nbi_nibble_asm #(.NIB_W(NIB_W)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .rs       (reg_sel),
        .nib      (db_in),
        .busy     (busy),
        .byte_q   (wr_byte),
        .stb_q    (stb),
        .err_q    (err),
        .at_lower (at_lower),
        .complete (complete)
    );

    nbi_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (complete),
        .busy (busy)
    );

    nbi_status_rd #(.NIB_W(NIB_W)) u_stat (
        .rd_status (rd_nwr && !reg_sel),
        .busy      (busy),
        .db_out    (db_out)
    );

    assign inst_wr = stb.inst;
    assign data_wr = stb.data;

endmodule

// File: rtl/nbi_checker.sv
module nbi_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic rd_nwr,
    input logic inst_wr,
    input logic data_wr,
    input logic busy,
    input logic err,
    input logic at_lower
);
    p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inst_wr, data_wr}));

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (inst_wr || data_wr) |=> !(inst_wr || data_wr));

    p_strobe_from_lower_r4: assert property (@(posedge clk) disable iff (rst)
        (inst_wr || data_wr) |-> $past(en && !rd_nwr && at_lower));

    p_busy_with_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (inst_wr || data_wr) |-> busy);

    p_reject_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !rd_nwr && !at_lower && busy) |=> (err && !at_lower));

    p_read_keeps_half_r8: assert property (@(posedge clk) disable iff (rst)
        (en && rd_nwr) |=> $stable(at_lower));

endmodule

bind nibble_bus_if nbi_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .rd_nwr   (rd_nwr),
    .inst_wr  (inst_wr),
    .data_wr  (data_wr),
    .busy     (busy),
    .err      (err),
    .at_lower (at_lower)
);

// File: tb/tb_nibble_bus_if.sv
module tb_nibble_bus_if;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_LEN   = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       rd_nwr = 1'b0;
    logic       en = 1'b0;
    logic [3:0] db_in = 4'h0;
    logic [3:0] db_out;
    logic [7:0] wr_byte;
    logic       inst_wr, data_wr, busy, err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model state
    bit       m_lower = 0;
    bit       m_rs = 0;
    bit [3:0] m_hi = 0;
    bit [7:0] m_byte = 0;
    int       m_cnt = 0;
    bit       m_inst = 0, m_data = 0, m_err = 0;

    nibble_bus_if dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .rd_nwr(rd_nwr), .en(en),
        .db_in(db_in), .db_out(db_out), .wr_byte(wr_byte),
        .inst_wr(inst_wr), .data_wr(data_wr), .busy(busy), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit [3:0] exp_status(input bit rw, input bit rs, input int cnt);
        return (rw && !rs) ? {(cnt != 0), 3'b000} : 4'h0;
    endfunction

    task automatic model_edge(input bit e, input bit rw, input bit rs, input bit [3:0] n);
        bit loaded = 0;
        m_inst = 0; m_data = 0; m_err = 0;
        if (e && !rw) begin
            if (!m_lower) begin
                if (m_cnt != 0) m_err = 1;               // R6
                else begin m_hi = n; m_rs = rs; m_lower = 1; end
            end else begin
                m_byte = {m_hi, n};                      // R2
                if (m_rs) m_data = 1; else m_inst = 1;   // R3
                m_lower = 0;
                m_cnt = BUSY_LEN;                        // R5
                loaded = 1;
            end
        end
        if (!loaded && m_cnt > 0) m_cnt--;
    endtask

    task automatic step(input bit e, input bit rw, input bit rs, input bit [3:0] n);
        bit strobe_due;
        en = e; rd_nwr = rw; reg_sel = rs; db_in = n;
        @(posedge clk);
        model_edge(e, rw, rs, n);
        #(CLK_PERIOD/4);
        strobe_due = m_inst || m_data;
        chk(strobe_due ? "R3" : "R4", "inst_wr", int'(inst_wr), int'(m_inst));
        chk(strobe_due ? "R3" : "R4", "data_wr", int'(data_wr), int'(m_data));
        chk("R2", "wr_byte", int'(wr_byte), int'(m_byte));
        chk("R5", "busy", int'(busy), int'(m_cnt != 0));
        chk("R6", "err", int'(err), int'(m_err));
        chk("R7", "db_out", int'(db_out), int'(exp_status(rw, rs, m_cnt)));
    endtask

    task automatic write_byte(input bit rs, input bit [7:0] b);
        step(1, 0, rs, b[7:4]);
        step(1, 0, rs, b[3:0]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset state while rst is high
        chk("R1", "inst_wr", int'(inst_wr), 0);
        chk("R1", "data_wr", int'(data_wr), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "err", int'(err), 0);
        chk("R1", "wr_byte", int'(wr_byte), 0);
        rst = 1'b0;
        // R1: first nibble after reset is the high half
        step(0, 0, 0, 4'h0);
        write_byte(0, 8'hA5);                 // R2, R3 instruction target
        chk("R2", "byte A5", int'(wr_byte), 8'hA5);
        repeat (9) step(0, 0, 0, 4'h0);        // R5 busy window
        step(1, 0, 1, 4'h3);                   // R6 10th edge: still busy, rejected
        chk("R6", "err pulse", int'(err), 1);
        step(1, 0, 1, 4'h3);                   // 11th edge: accepted as high half
        step(1, 1, 0, 4'h0);                   // R8 status read between halves
        step(1, 1, 1, 4'h0);                   // R8 data-side read, no effect
        step(1, 0, 0, 4'hC);                   // R3 low-half select ignored -> data
        chk("R3", "data target", int'(data_wr), 1);
        chk("R8", "byte after reads", int'(wr_byte), 8'h3C);
        repeat (12) step(0, 1, 0, 4'h0);       // R7 status polling through busy
        write_byte(1, 8'h0F);
        repeat (11) step(0, 0, 0, 4'h0);
        write_byte(0, 8'hF0);
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            bit e = (r < 40);
            bit rw = ($urandom_range(0, 3) == 0);
            step(e, rw, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
        end
        finish_run();
    end

endmodule